// File: doc/BRIEF.md
# DMA Channel Shutdown and Transfer-Error Capture

This block owns the closing side of a multi-channel DMA controller whose channels are spread over two buses. Each channel holds an active flag, a one-bit bus select, an interrupt enable, a flush attribute, and the current buffer address and remaining byte count. Software starts a channel by loading these fields. Write-completion strobes from the destination side advance the address and shrink the remaining size.

When the source signals done, the channel enters a drain phase. In that phase it keeps tracking the buffer and accepts the pipelined tail of data still in flight. The drain ends with a last-write strobe, or once the tail has reached its byte limit. At that point the block raises the completion interrupt and, if the flush attribute is set, a flush request. The active flag stays set until software clears it.

A transfer error reported on one bus clears the active flag of every channel assigned to that bus on a single clock edge. Channels on the other bus are left alone and close normally. The first error's bus, address and channel number are captured and held until software clears them. Any later error only sets a sticky overflow flag.

Top module: `dma_term_ctl`

## Requirements
- R1: After reset every active flag, drain flag, interrupt pulse, flush pulse, capture-valid and overflow output is 0.
- R2: A start pulse on channel c sets active[c] one cycle later and loads the bus select, interrupt enable, flush attribute, address and size, which the read port then returns for c.
- R3: A write strobe on an active channel adds its byte count to the address and subtracts it from the size, with the size held at 0 if the count exceeds it.
- R4: A done strobe on an active channel sets its drain flag. During the drain, writes keep updating address and size, and the active flag remains 1.
- R5: A write with the last flag set on a draining channel ends the drain. If interrupt enable is 1, irq[c] pulses for exactly one cycle, one cycle after that write.
- R6: A draining channel also closes on the write that brings the bytes written since done to TAIL_LIMIT (default 96) or more, even without the last flag.
- R7: A channel whose flush attribute is 1 pulses both flush[c] and irq[c] when its drain closes, whatever its interrupt enable. With both bits 0, nothing pulses at the close.
- R8: A software clear pulse on channel c drops active[c] one cycle later and produces no interrupt.
- R9: A bus error with bus value b clears, on the next edge, active and drain for every channel whose bus select equals b, and none of those channels raises an interrupt. Channels whose bus select differs keep their active flag and later close normally.
- R10: A bus error with the capture empty sets capture-valid one cycle later, with the failing bus, the 32-bit address and the channel number.
- R11: While capture-valid is 1, further bus errors leave bus, address and channel unchanged and set the sticky overflow flag.
- R12: A capture-clear pulse zeroes capture-valid and overflow. A bus error in the same cycle is captured as a fresh first error.
- R13: A completed drain does not clear the active flag. Only a software clear or a bus error does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for channel start_ch_i |
| start_ch_i | input | 4 | Channel being started |
| start_bus_i | input | 1 | Bus select loaded at start |
| start_ie_i | input | 1 | Interrupt enable loaded at start |
| start_fls_i | input | 1 | Flush attribute loaded at start |
| start_addr_i | input | 32 | Initial buffer address |
| start_size_i | input | 16 | Initial buffer size in bytes |
| sw_clr_i | input | 1 | Software clear pulse |
| sw_clr_ch_i | input | 4 | Channel being cleared |
| done_i | input | 1 | Source done strobe |
| done_ch_i | input | 4 | Channel that is done |
| wr_i | input | 1 | Destination write-completion strobe |
| wr_ch_i | input | 4 | Channel that was written |
| wr_bytes_i | input | 8 | Bytes written |
| wr_last_i | input | 1 | Marks the final write of the buffer |
| bus_err_i | input | 1 | Transfer error pulse |
| err_bus_i | input | 1 | Bus that failed |
| err_addr_i | input | 32 | Faulting address |
| err_ch_i | input | 4 | Channel that caused the error |
| err_clr_i | input | 1 | Clears the error capture |
| rd_ch_i | input | 4 | Channel selected on the read port |
| rd_addr_o | output | 32 | Current address of rd_ch_i |
| rd_size_o | output | 16 | Remaining size of rd_ch_i |
| active_o | output | 16 | Active flags |
| drain_o | output | 16 | Drain flags |
| irq_o | output | 16 | Completion interrupt pulses |
| flush_o | output | 16 | Flush request pulses |
| cap_valid_o | output | 1 | Error captured |
| cap_bus_o | output | 1 | Captured bus |
| cap_addr_o | output | 32 | Captured address |
| cap_ch_o | output | 4 | Captured channel |
| cap_ovf_o | output | 1 | Sticky overflow flag |

## Verification
Every state change is registered. Active, drain, capture and overflow reflect a stimulus one cycle after it, and irq and flush pulse in exactly that cycle and no other. The read port is combinational on the registered state, so it shows address and size one cycle after a write. Inputs are driven on the falling edge, and each expected pulse is queued with the cycle number one edge ahead. The monitor compares only in that cycle and flags any pulse that nobody queued. Level outputs are read at the falling edge after the capturing rising edge.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned SIZE_W = 16;
    parameter int unsigned CNT_W  = 8;
    parameter int unsigned TAIL_W = 12;

    typedef struct packed {
        logic              act;
        logic              bus;
        logic              ie;
        logic              fls;
        logic              drain;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [TAIL_W-1:0] tail;
        logic              irq;
        logic              flp;
    } chan_st_t;

    typedef struct packed {
        logic              valid;
        logic              bus;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        ch;
        logic              ovf;
    } cap_st_t;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_term_pkg::*;
#(
    parameter int unsigned TAIL_LIMIT = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bus_i,
    input  logic              ie_i,
    input  logic              fls_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              clr_i,
    input  logic              done_i,
    input  logic              wr_i,
    input  logic [CNT_W-1:0]  bytes_i,
    input  logic              last_i,
    input  logic              err_i,
    input  logic              err_bus_i,
    output logic              act_o,
    output logic              bus_o,
    output logic              drain_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              irq_o,
    output logic              flush_o
);
    localparam int unsigned SUM_W = TAIL_W + 1;

    chan_st_t st_d, st_q;
    logic              kill_w;
    logic [SIZE_W-1:0] bytes_sz_w;
    logic [SUM_W-1:0]  tail_sum_w;
    logic              close_w;

    always_comb begin
        kill_w     = err_i && (err_bus_i == st_q.bus);
        bytes_sz_w = SIZE_W'(bytes_i);
        tail_sum_w = SUM_W'(st_q.tail) + SUM_W'(bytes_i);
        close_w    = 1'b0;

        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.flp = 1'b0;

        if (kill_w) begin
            st_d.act   = 1'b0;
            st_d.drain = 1'b0;
        end else if (start_i) begin
            st_d.act   = 1'b1;
            st_d.bus   = bus_i;
            st_d.ie    = ie_i;
            st_d.fls   = fls_i;
            st_d.drain = 1'b0;
            st_d.addr  = addr_i;
            st_d.size  = size_i;
            st_d.tail  = '0;
        end else begin
            if (wr_i && st_q.act) begin
                st_d.addr = st_q.addr + ADDR_W'(bytes_i);
                st_d.size = (bytes_sz_w >= st_q.size) ? '0 : (st_q.size - bytes_sz_w);
                if (st_q.drain) begin
                    st_d.tail = tail_sum_w[TAIL_W-1:0];
                    if (last_i || (tail_sum_w >= SUM_W'(TAIL_LIMIT))) begin
                        close_w = 1'b1;
                    end
                end
            end
            if (done_i && st_q.act && !st_q.drain) begin
                st_d.drain = 1'b1;
                st_d.tail  = '0;
            end
            if (close_w) begin
                st_d.drain = 1'b0;
                st_d.irq   = st_q.ie | st_q.fls;
                st_d.flp   = st_q.fls;
            end
            if (clr_i) begin
                st_d.act   = 1'b0;
                st_d.drain = 1'b0;
                st_d.irq   = 1'b0;
                st_d.flp   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o   = st_q.act;
    assign bus_o   = st_q.bus;
    assign drain_o = st_q.drain;
    assign addr_o  = st_q.addr;
    assign size_o  = st_q.size;
    assign irq_o   = st_q.irq;
    assign flush_o = st_q.flp;
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
    import dma_term_pkg::*;
#(
    parameter int unsigned CH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic              bus_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic              clr_i,
    output logic              valid_o,
    output logic              bus_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              ovf_o
);
    cap_st_t cap_d, cap_q;
    logic    empty_w;

    always_comb begin
        cap_d   = cap_q;
        empty_w = !cap_q.valid;
        if (clr_i) begin
            cap_d   = '0;
            empty_w = 1'b1;
        end
        if (err_i) begin
            if (empty_w) begin
                cap_d.valid = 1'b1;
                cap_d.bus   = bus_i;
                cap_d.addr  = addr_i;
                cap_d.ch    = 8'(ch_i);
            end else begin
                cap_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign valid_o = cap_q.valid;
    assign bus_o   = cap_q.bus;
    assign addr_o  = cap_q.addr;
    assign ch_o    = cap_q.ch[CH_W-1:0];
    assign ovf_o   = cap_q.ovf;
endmodule

// File: rtl/dma_term_ctl.sv
module dma_term_ctl
    import dma_term_pkg::*;
#(
    parameter int unsigned NCH        = 16,
    parameter int unsigned TAIL_LIMIT = 96,
    localparam int unsigned CH_W      = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   start_ch_i,
    input  logic              start_bus_i,
    input  logic              start_ie_i,
    input  logic              start_fls_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [SIZE_W-1:0] start_size_i,
    input  logic              sw_clr_i,
    input  logic [CH_W-1:0]   sw_clr_ch_i,
    input  logic              done_i,
    input  logic [CH_W-1:0]   done_ch_i,
    input  logic              wr_i,
    input  logic [CH_W-1:0]   wr_ch_i,
    input  logic [CNT_W-1:0]  wr_bytes_i,
    input  logic              wr_last_i,
    input  logic              bus_err_i,
    input  logic              err_bus_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    input  logic [CH_W-1:0]   err_ch_i,
    input  logic              err_clr_i,
    input  logic [CH_W-1:0]   rd_ch_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [SIZE_W-1:0] rd_size_o,
    output logic [NCH-1:0]    active_o,
    output logic [NCH-1:0]    drain_o,
    output logic [NCH-1:0]    irq_o,
    output logic [NCH-1:0]    flush_o,
    output logic              cap_valid_o,
    output logic              cap_bus_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [CH_W-1:0]   cap_ch_o,
    output logic              cap_ovf_o
);
    logic [NCH-1:0]    bus_sel_w;
    logic [ADDR_W-1:0] addr_w [NCH];
    logic [SIZE_W-1:0] size_w [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit_start, hit_clr, hit_done, hit_wr;
        assign hit_start = start_i  && (start_ch_i  == CH_W'(g));
        assign hit_clr   = sw_clr_i && (sw_clr_ch_i == CH_W'(g));
        assign hit_done  = done_i   && (done_ch_i   == CH_W'(g));
        assign hit_wr    = wr_i     && (wr_ch_i     == CH_W'(g));

        dma_chan_slot #(.TAIL_LIMIT(TAIL_LIMIT)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (hit_start),
            .bus_i     (start_bus_i),
            .ie_i      (start_ie_i),
            .fls_i     (start_fls_i),
            .addr_i    (start_addr_i),
            .size_i    (start_size_i),
            .clr_i     (hit_clr),
            .done_i    (hit_done),
            .wr_i      (hit_wr),
            .bytes_i   (wr_bytes_i),
            .last_i    (wr_last_i),
            .err_i     (bus_err_i),
            .err_bus_i (err_bus_i),
            .act_o     (active_o[g]),
            .bus_o     (bus_sel_w[g]),
            .drain_o   (drain_o[g]),
            .addr_o    (addr_w[g]),
            .size_o    (size_w[g]),
            .irq_o     (irq_o[g]),
            .flush_o   (flush_o[g])
        );
    end

    assign rd_addr_o = addr_w[rd_ch_i];
    assign rd_size_o = size_w[rd_ch_i];

    dma_err_capture #(.CH_W(CH_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_i   (bus_err_i),
        .bus_i   (err_bus_i),
        .addr_i  (err_addr_i),
        .ch_i    (err_ch_i),
        .clr_i   (err_clr_i),
        .valid_o (cap_valid_o),
        .bus_o   (cap_bus_o),
        .addr_o  (cap_addr_o),
        .ch_o    (cap_ch_o),
        .ovf_o   (cap_ovf_o)
    );
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk
    import dma_term_pkg::*;
#(
    parameter int unsigned NCH = 16,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_i,
    input logic              bus_err_i,
    input logic              err_bus_i,
    input logic [ADDR_W-1:0] err_addr_i,
    input logic [CH_W-1:0]   err_ch_i,
    input logic              err_clr_i,
    input logic [NCH-1:0]    bus_sel_w,
    input logic [NCH-1:0]    active_o,
    input logic [NCH-1:0]    irq_o,
    input logic              cap_valid_o,
    input logic              cap_bus_o,
    input logic [ADDR_W-1:0] cap_addr_o,
    input logic [CH_W-1:0]   cap_ch_o,
    input logic              cap_ovf_o
);
    // R9
    kill_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_i |=> ((active_o & $past(err_bus_i ? bus_sel_w : ~bus_sel_w)) == '0));

    // R10
    first_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_i && (!cap_valid_o || err_clr_i)) |=>
            (cap_valid_o && cap_addr_o == $past(err_addr_i) &&
             cap_ch_o == $past(err_ch_i) && cap_bus_o == $past(err_bus_i)));

    // R11
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_o && !err_clr_i) |=>
            ($stable(cap_addr_o) && $stable(cap_ch_o) && $stable(cap_bus_o) && cap_valid_o));

    // R11
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_o && bus_err_i && !err_clr_i) |=> cap_ovf_o);

    // R5
    irq_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> $past(wr_i));

    // R12
    clr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !bus_err_i) |=> (!cap_valid_o && !cap_ovf_o));
endmodule

bind dma_term_ctl dma_term_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_term_ctl_test.sv
`timescale 1ns/1ps
module dma_term_ctl_test;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, start_bus_i = 0, start_ie_i = 0, start_fls_i = 0;
    logic [3:0]  start_ch_i = 0;
    logic [31:0] start_addr_i = 0;
    logic [15:0] start_size_i = 0;
    logic        sw_clr_i = 0;
    logic [3:0]  sw_clr_ch_i = 0;
    logic        done_i = 0;
    logic [3:0]  done_ch_i = 0;
    logic        wr_i = 0, wr_last_i = 0;
    logic [3:0]  wr_ch_i = 0;
    logic [7:0]  wr_bytes_i = 0;
    logic        bus_err_i = 0, err_bus_i = 0, err_clr_i = 0;
    logic [31:0] err_addr_i = 0;
    logic [3:0]  err_ch_i = 0;
    logic [3:0]  rd_ch_i = 0;
    logic [31:0] rd_addr_o;
    logic [15:0] rd_size_o;
    logic [NCH-1:0] active_o, drain_o, irq_o, flush_o;
    logic        cap_valid_o, cap_bus_o, cap_ovf_o;
    logic [31:0] cap_addr_o;
    logic [3:0]  cap_ch_o;

    dma_term_ctl uut (.*);

    always #2.5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int             due;
        logic [NCH-1:0] irq;
        logic [NCH-1:0] fl;
        string          tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // monitor: pulses must appear exactly in the cycle queued
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " irq"}, 64'(irq_o), 64'(e.irq));
                check({e.tag, " flush"}, 64'(flush_o), 64'(e.fl));
            end else if ((irq_o | flush_o) != '0) begin
                vectors++;
                miscompares++;
                $display("FAIL R5 unexpected pulse irq=%0h flush=%0h exp=0", irq_o, flush_o);
            end
        end
    end

    task automatic expect_pulse(string tag, int ch, logic fl);
        exp_t e;
        e.due = cyc + 1;
        e.irq = '0; e.irq[ch] = 1'b1;
        e.fl  = '0; e.fl[ch] = fl;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic start(int ch, logic bus, logic ie, logic fls, logic [31:0] a, logic [15:0] s);
        @(negedge clk);
        start_i = 1; start_ch_i = 4'(ch); start_bus_i = bus; start_ie_i = ie;
        start_fls_i = fls; start_addr_i = a; start_size_i = s;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wr(int ch, int n, logic last, logic exp_irq, logic exp_fl, string tag);
        @(negedge clk);
        wr_i = 1; wr_ch_i = 4'(ch); wr_bytes_i = 8'(n); wr_last_i = last;
        if (exp_irq) expect_pulse(tag, ch, exp_fl);
        @(negedge clk);
        wr_i = 0; wr_last_i = 0;
    endtask

    task automatic done(int ch);
        @(negedge clk);
        done_i = 1; done_ch_i = 4'(ch);
        @(negedge clk);
        done_i = 0;
    endtask

    task automatic swclr(int ch);
        @(negedge clk);
        sw_clr_i = 1; sw_clr_ch_i = 4'(ch);
        @(negedge clk);
        sw_clr_i = 0;
    endtask

    task automatic berr(logic bus, logic [31:0] a, int ch, logic clr);
        @(negedge clk);
        bus_err_i = 1; err_bus_i = bus; err_addr_i = a; err_ch_i = 4'(ch); err_clr_i = clr;
        @(negedge clk);
        bus_err_i = 0; err_clr_i = 0;
    endtask

    task automatic rd(int ch, string tag, logic [31:0] ea, logic [15:0] es);
        rd_ch_i = 4'(ch);
        #0.1;
        check({tag, " addr"}, 64'(rd_addr_o), 64'(ea));
        check({tag, " size"}, 64'(rd_size_o), 64'(es));
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 active", 64'(active_o), 0);
        check("R1 drain", 64'(drain_o), 0);
        check("R1 cap", 64'({cap_valid_o, cap_ovf_o}), 0);

        // R2 start loads fields
        start(3, 0, 1, 0, 32'h1000, 16'd256);
        check("R2 active", 64'(active_o[3]), 1);
        rd(3, "R2", 32'h1000, 16'd256);

        // R3 write advances
        wr(3, 32, 0, 0, 0, "R3");
        rd(3, "R3", 32'h1020, 16'd224);

        // R4 done -> drain, tracking continues
        done(3);
        check("R4 drain", 64'(drain_o[3]), 1);
        wr(3, 16, 0, 0, 0, "R4");
        rd(3, "R4", 32'h1030, 16'd208);
        check("R4 active", 64'(active_o[3]), 1);
        // R5 last write closes with irq
        wr(3, 8, 1, 1, 0, "R5");
        check("R5 drain end", 64'(drain_o[3]), 0);
        // R13 active kept after drain close
        check("R13 active kept", 64'(active_o[3]), 1);

        // R6 tail limit closes without last
        start(5, 1, 1, 0, 32'h0, 16'd1000);
        done(5);
        wr(5, 32, 0, 0, 0, "R6");
        wr(5, 32, 0, 0, 0, "R6");
        check("R6 still draining", 64'(drain_o[5]), 1);
        wr(5, 32, 0, 1, 0, "R6 tail");
        check("R6 drain end", 64'(drain_o[5]), 0);

        // R7 flush attribute with ie=0
        start(6, 0, 0, 1, 32'h2000, 16'd64);
        done(6);
        wr(6, 64, 1, 1, 1, "R7 flush");
        // R7 neither bit: silent close
        start(7, 1, 0, 0, 32'h3000, 16'd64);
        done(7);
        wr(7, 64, 1, 0, 0, "R7 silent");
        check("R7 silent drain end", 64'(drain_o[7]), 0);

        // R3 size floor
        start(8, 1, 0, 0, 32'h4000, 16'd10);
        wr(8, 20, 0, 0, 0, "R3 floor");
        rd(8, "R3 floor", 32'h4014, 16'd0);

        // R8 software clear
        swclr(3);
        check("R8 active", 64'(active_o[3]), 0);

        // R9 bus error on bus 0
        start(1, 0, 1, 0, 32'h5000, 16'd128);
        start(2, 0, 1, 0, 32'h6000, 16'd128);
        start(9, 1, 1, 0, 32'h7000, 16'd128);
        done(2);
        berr(0, 32'hDEADBEE0, 2, 0);
        check("R9 bus0 killed", 64'(active_o & 16'h0046), 0);
        check("R9 drain killed", 64'(drain_o[2]), 0);
        check("R9 bus1 alive", 64'(active_o & 16'h03A0), 64'h03A0);
        // R10 capture
        check("R10 valid", 64'(cap_valid_o), 1);
        check("R10 bus", 64'(cap_bus_o), 0);
        check("R10 addr", 64'(cap_addr_o), 64'hDEADBEE0);
        check("R10 ch", 64'(cap_ch_o), 2);
        check("R10 ovf", 64'(cap_ovf_o), 0);
        // R9 killed channel raises no irq on a later last write
        wr(2, 8, 1, 0, 0, "R9 no irq");
        // R9 other bus closes normally
        done(9);
        wr(9, 16, 1, 1, 0, "R9 other bus");

        // R11 second error: overflow, capture held
        berr(1, 32'h12345678, 9, 0);
        check("R11 ovf", 64'(cap_ovf_o), 1);
        check("R11 addr held", 64'(cap_addr_o), 64'hDEADBEE0);
        check("R11 ch held", 64'(cap_ch_o), 2);
        check("R9 bus1 killed", 64'(active_o & 16'h03A0), 0);

        // R12 clear
        @(negedge clk); err_clr_i = 1;
        @(negedge clk); err_clr_i = 0;
        check("R12 cleared", 64'({cap_valid_o, cap_ovf_o}), 0);
        berr(1, 32'hCAFE0000, 5, 0);
        berr(0, 32'hBEEF0000, 4, 1);
        check("R12 fresh valid", 64'(cap_valid_o), 1);
        check("R12 fresh addr", 64'(cap_addr_o), 64'hBEEF0000);
        check("R12 fresh ch", 64'(cap_ch_o), 4);
        check("R12 ovf clear", 64'(cap_ovf_o), 0);

        repeat (4) @(negedge clk);
        check("R5 queue drained", 64'(sb.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule